// File: doc/BRIEF.md
# Asynchronous HDLC Receive Framer

This block sits behind a byte-level asynchronous serial receiver. That receiver has already recovered each character and marks break characters and idle bits. The framer looks for frame boundaries marked by the flag byte and undoes control-escape transparency. It runs a CRC-16 over every frame. Payload bytes go out on a plain valid/data byte stream, and each frame ends with a one-cycle frame event that carries a status word: a CRC-error flag, a break flag and a byte count.

A frame with a good check sequence is delivered without its two check bytes. A frame whose check fails is delivered with its check bytes included, so software can inspect them. A break character cuts the current frame short, and no CRC check is made on it. Two separate pulses mark the first break character of a sequence and the first idle bit after that sequence. The upstream receiver must space characters (data or break) at least four clock cycles apart. A real serial line always meets this.

Top module: `hdlc_rx_framer`

## Requirements
- R1: Out of reset the framer hunts and ignores every byte until it sees a flag 0x7E. A flag that closes one frame also opens the next one.
- R2: Inside a frame, the escape byte 0x7D is dropped and the byte that follows it is XORed with 0x20 before use.
- R3: The CRC is CRC-16 with the reflected polynomial 0x1021 and a preset of 0xFFFF. The sender appends the ones' complement of the register, low byte first. A frame whose bytes, check bytes included, leave the residue 0xF0B8 is good. Its bytes except the last two are output in order, followed by ev_frame with stat_crc_err=0, stat_break=0 and stat_len equal to the payload byte count.
- R4: A frame that fails the check has all of its bytes output, the two check bytes included. It is then closed by ev_frame with stat_crc_err=1, stat_break=0 and stat_len equal to the full byte count.
- R5: After a CRC-error frame the next frame is received normally, with no other action.
- R6: A break character that arrives after at least one byte of an open frame does the following: it outputs the remaining bytes, raises ev_frame with stat_break=1, stat_crc_err=0 and stat_len equal to all bytes received, and returns the framer to hunting.
- R7: ev_brk_start pulses once for the first break character of a sequence. Later break characters in the same sequence raise no further pulse.
- R8: ev_brk_end pulses on the first idle bit after a break sequence. An idle bit outside a break sequence has no effect.
- R9: Back-to-back flags, and frames with fewer than two bytes, produce no output byte and no ev_frame.
- R10: After reset, out_valid, ev_frame, ev_brk_start and ev_brk_end are low, and the status outputs are zero.
- R11: ev_frame is a single-cycle pulse. It never shares a cycle with out_valid, and it follows the last byte of its frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_valid | input | 1 | rx_data holds a received character |
| rx_data | input | 8 | Received character |
| rx_break | input | 1 | A break character was received |
| rx_idle | input | 1 | An idle bit was received |
| out_valid | output | 1 | out_data holds a frame byte |
| out_data | output | 8 | Frame byte, unescaped |
| ev_frame | output | 1 | Frame closed, status valid |
| stat_crc_err | output | 1 | Closed frame failed its CRC |
| stat_break | output | 1 | Closed frame was ended by a break |
| stat_len | output | LEN_W | Bytes output for the closed frame |
| ev_brk_start | output | 1 | First break character of a sequence |
| ev_brk_end | output | 1 | First idle bit after a break sequence |

## Verification
The hardest state to reach is a frame being drained in the flush state, where the last two held bytes are released and then the status follows. The stimulus gets there in two ways. One is a check sequence with a flipped bit. The other is a break that arrives after one byte and after several bytes, so the hold buffer is drained from both a partly full and a full state. The stimulus then repeats the break and adds idle bits, to show that only the first of each raises an event. A clean frame follows straight after, to show that recovery needs no help.

// File: rtl/hdlc_rx_pkg.sv
package hdlc_rx_pkg;

    localparam logic [7:0]  FLAG_BYTE    = 8'h7E;
    localparam logic [7:0]  ESC_BYTE     = 8'h7D;
    localparam logic [7:0]  ESC_MASK     = 8'h20;
    localparam logic [15:0] CRC_SEED     = 16'hFFFF;
    localparam logic [15:0] CRC_RESIDUE  = 16'hF0B8;
    localparam logic [15:0] CRC_POLY_REV = 16'h8408;
    localparam int          FCS_BYTES    = 2;

    typedef enum logic [1:0] {TK_NONE, TK_DATA, TK_FLAG, TK_BREAK} tok_kind_e;

    typedef struct packed {
        tok_kind_e  kind;
        logic [7:0] value;
    } rx_tok_t;

    typedef enum logic [1:0] {ST_HUNT, ST_FRAME, ST_FLUSH} rx_state_e;

    // One byte through the reflected CRC-16 register, LSB first.
    function automatic logic [15:0] crc_update(input logic [15:0] c, input logic [7:0] b);
        logic [15:0] r;
        r = c;
        for (int i = 0; i < 8; i++) begin
            if (r[0] ^ b[i]) r = (r >> 1) ^ CRC_POLY_REV;
            else             r = r >> 1;
        end
        return r;
    endfunction

endpackage

// File: rtl/hdlc_rx_unstuff.sv
module hdlc_rx_unstuff
    import hdlc_rx_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       rx_valid,
    input  logic [7:0] rx_data,
    input  logic       rx_break,
    output rx_tok_t    tok
);
    logic esc_q;

    always_comb begin
        tok.kind  = TK_NONE;
        tok.value = rx_data;
        if (rx_break) begin
            tok.kind = TK_BREAK;
        end else if (rx_valid) begin
            if (rx_data == FLAG_BYTE) begin
                tok.kind = TK_FLAG;
            end else if (rx_data != ESC_BYTE) begin
                tok.kind  = TK_DATA;
                tok.value = esc_q ? (rx_data ^ ESC_MASK) : rx_data;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            esc_q <= 1'b0;
        end else if (rx_break) begin
            esc_q <= 1'b0;
        end else if (rx_valid) begin
            esc_q <= (rx_data == ESC_BYTE);
        end
    end
endmodule

// File: rtl/hdlc_rx_crc.sv
module hdlc_rx_crc
    import hdlc_rx_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       clear,
    input  logic       advance,
    input  logic [7:0] din,
    output logic       crc_ok
);
    logic [15:0] crc_q;

    always_ff @(posedge clk) begin
        if (rst || clear) crc_q <= CRC_SEED;
        else if (advance) crc_q <= crc_update(crc_q, din);
    end

    assign crc_ok = (crc_q == CRC_RESIDUE);
endmodule

// File: rtl/hdlc_rx_hold.sv
module hdlc_rx_hold #(
    parameter int DEPTH = 2,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clear,
    input  logic          push,
    input  logic [7:0]    din,
    input  logic          pop,
    output logic [CW-1:0] cnt,
    output logic          full,
    output logic [7:0]    oldest
);
    logic [CW-1:0] cnt_q;
    logic [7:0]    slot_q [DEPTH];
    logic          shift;

    assign full   = (cnt_q == CW'(DEPTH));
    assign shift  = (push && full) || (pop && cnt_q != '0);
    assign cnt    = cnt_q;
    assign oldest = slot_q[0];

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        logic [7:0] q;
        logic [7:0] nxt;
        if (g == DEPTH - 1) begin : g_last
            assign nxt = push ? din : q;
        end else begin : g_inner
            assign nxt = slot_q[g+1];
        end
        always_ff @(posedge clk) begin
            if (rst) begin
                q <= '0;
            end else if (shift) begin
                q <= nxt;
            end else if (push && !full && cnt_q == CW'(g)) begin
                q <= din;
            end
        end
        assign slot_q[g] = q;
    end

    always_ff @(posedge clk) begin
        if (rst || clear)               cnt_q <= '0;
        else if (push && !full)         cnt_q <= cnt_q + 1'b1;
        else if (pop && cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
    end
endmodule

// File: rtl/hdlc_rx_brk.sv
module hdlc_rx_brk (
    input  logic clk,
    input  logic rst,
    input  logic rx_break,
    input  logic rx_idle,
    output logic brk_start,
    output logic brk_end
);
    logic in_brk_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            in_brk_q  <= 1'b0;
            brk_start <= 1'b0;
            brk_end   <= 1'b0;
        end else begin
            brk_start <= rx_break && !in_brk_q;
            brk_end   <= in_brk_q && rx_idle && !rx_break;
            if (rx_break)     in_brk_q <= 1'b1;
            else if (rx_idle) in_brk_q <= 1'b0;
        end
    end
endmodule

// File: rtl/hdlc_rx_framer.sv
module hdlc_rx_framer
    import hdlc_rx_pkg::*;
#(
    parameter int LEN_W = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             rx_valid,
    input  logic [7:0]       rx_data,
    input  logic             rx_break,
    input  logic             rx_idle,
    output logic             out_valid,
    output logic [7:0]       out_data,
    output logic             ev_frame,
    output logic             stat_crc_err,
    output logic             stat_break,
    output logic [LEN_W-1:0] stat_len,
    output logic             ev_brk_start,
    output logic             ev_brk_end
);
    localparam int               HOLD_CW = $clog2(FCS_BYTES + 1);
    localparam logic [LEN_W-1:0] LEN_MAX = '1;
    localparam logic [LEN_W-1:0] LEN_FCS = LEN_W'(FCS_BYTES);

    rx_tok_t          tok;
    rx_state_e        state_q, resume_q;
    logic [LEN_W-1:0] cnt_q, pend_len_q;
    logic             pend_crc_q, pend_brk_q;
    logic             crc_ok, hold_full;
    logic [HOLD_CW-1:0] hold_cnt;
    logic [7:0]       hold_oldest;
    logic             in_frame, is_data, close_flag, is_brk;
    logic             frame_short, hold_clear, hold_pop, crc_clear;

    assign in_frame    = (state_q == ST_FRAME);
    assign is_data     = in_frame && tok.kind == TK_DATA;
    assign close_flag  = in_frame && tok.kind == TK_FLAG;
    assign is_brk      = in_frame && tok.kind == TK_BREAK;
    assign frame_short = (cnt_q < LEN_FCS);
    assign hold_clear  = close_flag && (frame_short || crc_ok);
    assign hold_pop    = (state_q == ST_FLUSH) && hold_cnt != '0;
    assign crc_clear   = (state_q != ST_FLUSH) && tok.kind == TK_FLAG;

    hdlc_rx_unstuff u_unstuff (
        .clk      (clk),
        .rst      (rst),
        .rx_valid (rx_valid),
        .rx_data  (rx_data),
        .rx_break (rx_break),
        .tok      (tok)
    );

    hdlc_rx_crc u_crc (
        .clk     (clk),
        .rst     (rst),
        .clear   (crc_clear),
        .advance (is_data),
        .din     (tok.value),
        .crc_ok  (crc_ok)
    );

    hdlc_rx_hold #(.DEPTH(FCS_BYTES)) u_hold (
        .clk    (clk),
        .rst    (rst),
        .clear  (hold_clear),
        .push   (is_data),
        .din    (tok.value),
        .pop    (hold_pop),
        .cnt    (hold_cnt),
        .full   (hold_full),
        .oldest (hold_oldest)
    );

    hdlc_rx_brk u_brk (
        .clk       (clk),
        .rst       (rst),
        .rx_break  (rx_break),
        .rx_idle   (rx_idle),
        .brk_start (ev_brk_start),
        .brk_end   (ev_brk_end)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q      <= ST_HUNT;
            resume_q     <= ST_HUNT;
            cnt_q        <= '0;
            pend_len_q   <= '0;
            pend_crc_q   <= 1'b0;
            pend_brk_q   <= 1'b0;
            out_valid    <= 1'b0;
            out_data     <= '0;
            ev_frame     <= 1'b0;
            stat_crc_err <= 1'b0;
            stat_break   <= 1'b0;
            stat_len     <= '0;
        end else begin
            out_valid <= (is_data && hold_full) || hold_pop;
            if ((is_data && hold_full) || hold_pop) out_data <= hold_oldest;
            ev_frame <= 1'b0;

            unique case (state_q)
                ST_HUNT: begin
                    if (tok.kind == TK_FLAG) begin
                        state_q <= ST_FRAME;
                        cnt_q   <= '0;
                    end
                end
                ST_FRAME: begin
                    if (is_data) begin
                        if (cnt_q != LEN_MAX) cnt_q <= cnt_q + 1'b1;
                    end else if (close_flag) begin
                        cnt_q <= '0;
                        if (!frame_short) begin
                            if (crc_ok) begin
                                ev_frame     <= 1'b1;
                                stat_crc_err <= 1'b0;
                                stat_break   <= 1'b0;
                                stat_len     <= cnt_q - LEN_FCS;
                            end else begin
                                pend_crc_q <= 1'b1;
                                pend_brk_q <= 1'b0;
                                pend_len_q <= cnt_q;
                                resume_q   <= ST_FRAME;
                                state_q    <= ST_FLUSH;
                            end
                        end
                    end else if (is_brk) begin
                        cnt_q <= '0;
                        if (cnt_q == '0) begin
                            state_q <= ST_HUNT;
                        end else begin
                            pend_crc_q <= 1'b0;
                            pend_brk_q <= 1'b1;
                            pend_len_q <= cnt_q;
                            resume_q   <= ST_HUNT;
                            state_q    <= ST_FLUSH;
                        end
                    end
                end
                ST_FLUSH: begin
                    if (hold_cnt == '0) begin
                        ev_frame     <= 1'b1;
                        stat_crc_err <= pend_crc_q;
                        stat_break   <= pend_brk_q;
                        stat_len     <= pend_len_q;
                        state_q      <= resume_q;
                    end
                end
                default: state_q <= ST_HUNT;
            endcase
        end
    end
endmodule

// File: rtl/hdlc_rx_framer_sva.sv
module hdlc_rx_framer_sva (
    input logic clk,
    input logic rst,
    input logic out_valid,
    input logic ev_frame,
    input logic stat_crc_err,
    input logic stat_break,
    input logic ev_brk_start,
    input logic ev_brk_end
);
    logic seen_start_q;

    always_ff @(posedge clk) begin
        if (rst)               seen_start_q <= 1'b0;
        else if (ev_brk_start) seen_start_q <= 1'b1;
        else if (ev_brk_end)   seen_start_q <= 1'b0;
    end

    assert_frame_pulse_R11: assert property (@(posedge clk) disable iff (rst)
        ev_frame |=> !ev_frame);

    assert_data_status_apart_R11: assert property (@(posedge clk) disable iff (rst)
        !(out_valid && ev_frame));

    assert_status_exclusive_R6: assert property (@(posedge clk) disable iff (rst)
        ev_frame |-> !(stat_crc_err && stat_break));

    assert_brk_start_once_R7: assert property (@(posedge clk) disable iff (rst)
        ev_brk_start |-> !seen_start_q);

    assert_brk_end_follows_R8: assert property (@(posedge clk) disable iff (rst)
        ev_brk_end |-> seen_start_q);

    assert_quiet_after_reset_R10: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!out_valid && !ev_frame && !ev_brk_start && !ev_brk_end));
endmodule

bind hdlc_rx_framer hdlc_rx_framer_sva sva_i (
    .clk          (clk),
    .rst          (rst),
    .out_valid    (out_valid),
    .ev_frame     (ev_frame),
    .stat_crc_err (stat_crc_err),
    .stat_break   (stat_break),
    .ev_brk_start (ev_brk_start),
    .ev_brk_end   (ev_brk_end)
);

// File: tb/hdlc_rx_framer_tb_top.sv
`timescale 1ns/1ps
module hdlc_rx_framer_tb_top;
    localparam int LEN_W = 12;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic rx_valid = 1'b0, rx_break = 1'b0, rx_idle = 1'b0;
    logic [7:0] rx_data = '0;
    logic out_valid, ev_frame, stat_crc_err, stat_break, ev_brk_start, ev_brk_end;
    logic [7:0] out_data;
    logic [LEN_W-1:0] stat_len;

    always #2 clk = ~clk;

    hdlc_rx_framer #(.LEN_W(LEN_W)) dut_i (
        .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_data(rx_data),
        .rx_break(rx_break), .rx_idle(rx_idle), .out_valid(out_valid),
        .out_data(out_data), .ev_frame(ev_frame), .stat_crc_err(stat_crc_err),
        .stat_break(stat_break), .stat_len(stat_len),
        .ev_brk_start(ev_brk_start), .ev_brk_end(ev_brk_end));

    // kind[9:8]: 0 good, 1 bad CRC, 2 break; len[7:0] payload bytes
    localparam logic [9:0] VEC [8] = '{
        {2'd0, 8'd5}, {2'd1, 8'd4}, {2'd0, 8'd0}, {2'd2, 8'd3},
        {2'd0, 8'd12}, {2'd2, 8'd1}, {2'd1, 8'd1}, {2'd0, 8'd2}};

    int n_chk = 0, n_err = 0;
    int got_n = 0, ev_n = 0, bs_n = 0, be_n = 0;
    logic [7:0] got [64];
    logic [7:0] pbuf [64];
    logic [7:0] expb [64];
    int exp_n;
    logic s_crc, s_brk;
    int s_len;
    logic [7:0] fcs_lo, fcs_hi;

    always @(negedge clk) begin
        if (!rst) begin
            if (out_valid) begin
                if (got_n < 64) got[got_n] = out_data;
                got_n++;
            end
            if (ev_frame) begin
                ev_n++; s_crc = stat_crc_err; s_brk = stat_break; s_len = int'(stat_len);
            end
            if (ev_brk_start) bs_n++;
            if (ev_brk_end)   be_n++;
        end
    end

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic logic [15:0] crc_b(input logic [15:0] c, input logic [7:0] b);
        logic [15:0] r = c;
        for (int i = 0; i < 8; i++) r = (r[0] ^ b[i]) ? ((r >> 1) ^ 16'h8408) : (r >> 1);
        return r;
    endfunction

    function automatic logic [7:0] pay(input int k, input int i);
        if (i == 1) return 8'h7D;
        return 8'((k * 29 + i * 53 + 126) & 255);
    endfunction

    task automatic send_raw(input logic [7:0] b);
        @(negedge clk); rx_valid = 1'b1; rx_data = b;
        @(negedge clk); rx_valid = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic send_esc(input logic [7:0] b);
        if (b == 8'h7E || b == 8'h7D) begin
            send_raw(8'h7D); send_raw(b ^ 8'h20);
        end else send_raw(b);
    endtask

    task automatic send_brk();
        @(negedge clk); rx_break = 1'b1;
        @(negedge clk); rx_break = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic send_idle();
        @(negedge clk); rx_idle = 1'b1;
        @(negedge clk); rx_idle = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    // payload from pbuf, then FCS (optionally corrupted), no flags
    task automatic send_body(input int n, input bit corrupt);
        logic [15:0] c = 16'hFFFF;
        for (int i = 0; i < n; i++) begin
            c = crc_b(c, pbuf[i]);
            send_esc(pbuf[i]);
        end
        c = ~c;
        fcs_lo = c[7:0] ^ (corrupt ? 8'h01 : 8'h00);
        fcs_hi = c[15:8];
        send_esc(fcs_lo);
        send_esc(fcs_hi);
    endtask

    task automatic clear_mon();
        got_n = 0; ev_n = 0;
    endtask

    task automatic cmp_bytes(input string req);
        chk(got_n == exp_n, req, "byte count", got_n, exp_n);
        for (int i = 0; i < exp_n && i < got_n; i++)
            chk(got[i] == expb[i], req, "byte value", int'(got[i]), int'(expb[i]));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        int bs0, be0, kind, len;
        bit prev_bad;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R10 reset state
        chk(out_valid == 0 && ev_frame == 0, "R10", "out/ev after reset", int'(out_valid), 0);
        chk(ev_brk_start == 0 && ev_brk_end == 0, "R10", "break events after reset", int'(ev_brk_start), 0);
        chk(stat_len == 0 && stat_crc_err == 0 && stat_break == 0, "R10", "status after reset", int'(stat_len), 0);

        // R1: junk while hunting, then two frames sharing a flag
        clear_mon();
        send_raw(8'hAB); send_raw(8'h55);
        send_raw(8'h7E);
        pbuf[0] = 8'h11; pbuf[1] = 8'h22; pbuf[2] = 8'h33;
        send_body(3, 1'b0);
        send_raw(8'h7E);
        pbuf[0] = 8'h44; pbuf[1] = 8'h7E;
        send_body(2, 1'b0);
        send_raw(8'h7E);
        repeat (6) @(negedge clk);
        exp_n = 5;
        expb[0] = 8'h11; expb[1] = 8'h22; expb[2] = 8'h33; expb[3] = 8'h44; expb[4] = 8'h7E;
        chk(ev_n == 2, "R1", "frames with shared flag", ev_n, 2);
        cmp_bytes("R1");
        chk(s_len == 2 && !s_crc, "R1", "second frame length", s_len, 2);

        // Vector table
        prev_bad = 1'b0;
        for (int k = 0; k < 8; k++) begin
            kind = int'(VEC[k][9:8]);
            len  = int'(VEC[k][7:0]);
            clear_mon();
            bs0 = bs_n; be0 = be_n;
            for (int i = 0; i < len; i++) begin
                pbuf[i] = pay(k, i);
                expb[i] = pay(k, i);
            end
            exp_n = len;
            send_raw(8'h7E);
            if (kind == 2) begin
                for (int i = 0; i < len; i++) send_esc(pbuf[i]);
                send_brk(); send_brk(); send_brk();
                repeat (6) @(negedge clk);
                chk(bs_n - bs0 == 1, "R7", "break start pulses", bs_n - bs0, 1);
                chk(be_n - be0 == 0, "R8", "no end before idle", be_n - be0, 0);
                send_idle();
                send_idle();
                repeat (6) @(negedge clk);
                chk(be_n - be0 == 1, "R8", "break end pulses", be_n - be0, 1);
                cmp_bytes("R6");
                chk(ev_n == 1, "R6", "break frame event", ev_n, 1);
                chk(s_brk == 1 && s_crc == 0, "R6", "break status flags", int'({s_brk, s_crc}), 2);
                chk(s_len == len, "R6", "break frame length", s_len, len);
            end else begin
                send_body(len, kind == 1);
                send_raw(8'h7E);
                repeat (6) @(negedge clk);
                if (kind == 1) begin
                    expb[len] = fcs_lo; expb[len+1] = fcs_hi; exp_n = len + 2;
                    cmp_bytes("R4");
                    chk(ev_n == 1, "R4", "bad frame event", ev_n, 1);
                    chk(s_crc == 1 && s_brk == 0, "R4", "bad frame flags", int'({s_brk, s_crc}), 1);
                    chk(s_len == len + 2, "R4", "bad frame length", s_len, len + 2);
                end else begin
                    cmp_bytes(prev_bad ? "R5" : "R3");
                    chk(ev_n == 1, prev_bad ? "R5" : "R3", "good frame event", ev_n, 1);
                    chk(s_crc == 0 && s_brk == 0, "R3", "good frame flags", int'({s_brk, s_crc}), 0);
                    chk(s_len == len, "R3", "good frame length", s_len, len);
                end
            end
            prev_bad = (kind == 1);
        end

        // R9: back-to-back flags and a one-byte frame
        clear_mon();
        send_raw(8'h7E); send_raw(8'h7E); send_raw(8'h7E);
        send_raw(8'h5A); send_raw(8'h7E);
        repeat (6) @(negedge clk);
        chk(ev_n == 0, "R9", "no event for short frames", ev_n, 0);
        chk(got_n == 0, "R9", "no bytes for short frames", got_n, 0);

        // R8: idle with no break pending
        be0 = be_n;
        send_idle();
        repeat (4) @(negedge clk);
        chk(be_n == be0, "R8", "idle alone gives no end", be_n - be0, 0);

        // R2: hand-escaped payload 7D 5E -> 7E, 7D 5D -> 7D
        clear_mon();
        send_raw(8'h7E);
        send_raw(8'h7D); send_raw(8'h5E);
        send_raw(8'h7D); send_raw(8'h5D);
        pbuf[0] = 8'h7E; pbuf[1] = 8'h7D;
        begin
            logic [15:0] c;
            c = ~crc_b(crc_b(16'hFFFF, 8'h7E), 8'h7D);
            send_esc(c[7:0]); send_esc(c[15:8]);
        end
        send_raw(8'h7E);
        repeat (6) @(negedge clk);
        exp_n = 2; expb[0] = 8'h7E; expb[1] = 8'h7D;
        cmp_bytes("R2");
        chk(ev_n == 1 && !s_crc, "R2", "escaped frame passes CRC", int'(s_crc), 0);

        $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule